// File: doc/BRIEF.md
# Pipeline Stage Segment-Error Calibration Engine

This block is the digital half of a foreground calibration for one multi-bit stage of a pipelined converter. When a sweep is started, it takes over the stage DAC code and walks it through every segment. A segment is the step from code k to code k+1. For each segment the block averages the back-end result twice. The first average is taken with the code held at k, which captures the switch feedthrough level. The second average is taken with the code raised to k+1.

The difference between the two averages, less the ideal step, is the segment error. The block keeps a running sum of these errors in an on-chip table that holds one signed entry per stage code. Each entry carries two extra fractional bits. Code 0 is the reference and always stores zero.

Outside a sweep the stage code passes straight through to the DAC. Each cycle, the table entry for the current code is subtracted from the raw output word, after that word has been scaled to the fractional resolution of the table. For a one-bit stage the sweep has a single segment, and that segment error is the bit error.

Top module: `seg_cal_engine`

## Requirements
- R1: After reset, busy, done and corr_word are 0 and every table entry is 0, so that before any sweep corr_word equals raw_word times 4.
- R2: A cal_start seen while idle raises busy on the next cycle. busy then stays high for exactly (2^STAGE_BITS-1)·2·2^AVG_BITS cycles, which is 56 with the default parameters. A cal_start seen while busy has no effect on this length.
- R3: During a sweep, segment k presents stage_code = k for 2^AVG_BITS cycles and then stage_code = k+1 for 2^AVG_BITS cycles. Segments run in increasing order of k, from 0 to 2^STAGE_BITS-2.
- R4: While not busy, stage_code equals code_in in the same cycle.
- R5: The segment error for segment k is (sum of the back-end results at code k+1) − (sum of the back-end results at code k) − IDEAL_STEP·2^AVG_BITS. This value is then arithmetic-shifted so that it carries FRAC_BITS fractional bits. With the defaults (AVG_BITS = FRAC_BITS = 2) the shift is zero.
- R6: Table entry 0 stays 0. Entry k+1 is written with entry k plus the error of segment k, as a two's complement value.
- R7: While not busy, corr_word is updated one cycle after its inputs to raw_word·2^FRAC_BITS − table[code_in], as a signed value.
- R8: While busy, corr_word holds its value.
- R9: done is high for exactly one cycle. That cycle is the first cycle in which busy is low after the last table entry has been written.
- R10: After a sweep with a noise-free back end, corrected words are linear in code. For raw = k·IDEAL_STEP + inj[k] + v, where inj[k] is the error of the back end at code k, corr_word equals 4·(k·IDEAL_STEP + v + inj[0]).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_start | input | 1 | Starts a sweep when idle |
| code_in | input | STAGE_BITS | Stage code from the sub-ADC in normal operation |
| raw_word | input | RAW_W | Assembled uncorrected output word |
| be_result | input | BE_W | Back-end digital result for the code on stage_code |
| stage_code | output | STAGE_BITS | Code driven to the stage DAC |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle pulse at the end of a sweep |
| corr_word | output | CORR_W | Signed corrected word with FRAC_BITS fractional bits |

## Verification
The assertions assume that be_result is valid in the same cycle as the stage_code that produced it, with no added latency. They also assume that code_in and raw_word change only between clock edges. The bench's back end is a combinational function of stage_code plus a small deterministic dither, and the bench drives every input shortly after a rising edge. The injected errors and the dither are kept small enough that no sum leaves the range of the back-end word or of the table.

// File: rtl/seg_cal_pkg.sv
package seg_cal_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_FEED = 2'd1,
        PH_STEP = 2'd2
    } cal_phase_e;

    typedef struct packed {
        logic busy;
        logic done;
    } cal_status_t;

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cal_sequencer.sv
module cal_sequencer
    import seg_cal_pkg::*;
#(
    parameter int unsigned STAGE_BITS = 3,
    parameter int unsigned BE_W       = 10,
    parameter int unsigned AVG_BITS   = 2,
    parameter int unsigned FRAC_BITS  = 2,
    parameter int unsigned IDEAL_STEP = 64,
    localparam int unsigned SUM_W     = BE_W + AVG_BITS,
    localparam int unsigned DIFF_W    = SUM_W + 2,
    localparam int unsigned SEG_W     = DIFF_W + FRAC_BITS
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [BE_W-1:0]         be_result,
    output logic [STAGE_BITS-1:0]   cal_code,
    output cal_status_t             status,
    output logic                    wr_en,
    output logic [STAGE_BITS-1:0]   wr_addr,
    output logic signed [SEG_W-1:0] seg_err
);
    localparam int unsigned REP_W    = (AVG_BITS > 0) ? AVG_BITS : 1;
    localparam int unsigned REPS     = 1 << AVG_BITS;
    localparam logic [STAGE_BITS-1:0] LAST_SEG = STAGE_BITS'((1 << STAGE_BITS) - 2);
    localparam logic [REP_W-1:0] REP_LAST = REP_W'(REPS - 1);
    localparam logic signed [DIFF_W-1:0] IDEAL_SUM = DIFF_W'(IDEAL_STEP << AVG_BITS);

    cal_phase_e             phase;
    logic [STAGE_BITS-1:0]  seg_idx;
    logic [REP_W-1:0]       rep;
    logic [SUM_W-1:0]       acc_a, acc_b, b_total;
    logic                   rep_last, busy, done_q;
    logic signed [DIFF_W-1:0] diff;
    logic signed [SEG_W-1:0]  diff_ext;

    assign busy     = (phase != PH_IDLE);
    assign rep_last = (rep == REP_LAST);
    assign cal_code = (phase == PH_STEP) ? seg_idx + STAGE_BITS'(1) : seg_idx;
    assign b_total  = ((rep == '0) ? '0 : acc_b) + SUM_W'(be_result);
    assign diff     = $signed({2'b00, b_total}) - $signed({2'b00, acc_a}) - IDEAL_SUM;
    assign diff_ext = SEG_W'(diff);

    generate
        if (AVG_BITS >= FRAC_BITS) begin : g_shr
            assign seg_err = diff_ext >>> (AVG_BITS - FRAC_BITS);
        end else begin : g_shl
            assign seg_err = diff_ext <<< (FRAC_BITS - AVG_BITS);
        end
    endgenerate

    assign wr_en   = (phase == PH_STEP) && rep_last;
    assign wr_addr = seg_idx + STAGE_BITS'(1);
    assign status  = '{busy: busy, done: done_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            seg_idx <= '0;
            rep     <= '0;
            acc_a   <= '0;
            acc_b   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase   <= PH_FEED;
                        seg_idx <= '0;
                        rep     <= '0;
                    end
                end
                PH_FEED: begin
                    acc_a <= ((rep == '0) ? '0 : acc_a) + SUM_W'(be_result);
                    rep   <= rep + REP_W'(1);
                    if (rep_last) begin
                        phase <= PH_STEP;
                        rep   <= '0;
                    end
                end
                PH_STEP: begin
                    acc_b <= b_total;
                    rep   <= rep + REP_W'(1);
                    if (rep_last) begin
                        rep <= '0;
                        if (seg_idx == LAST_SEG) begin
                            phase  <= PH_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            seg_idx <= seg_idx + STAGE_BITS'(1);
                            phase   <= PH_FEED;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R3
    code_step_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (cal_code == $past(cal_code) || cal_code == $past(cal_code) + STAGE_BITS'(1)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R9
    done_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done_q);

endmodule

// File: rtl/cal_err_table.sv
module cal_err_table #(
    parameter int unsigned STAGE_BITS = 3,
    parameter int unsigned SEG_W      = 16,
    parameter int unsigned ERR_W      = 19
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [STAGE_BITS-1:0]   wr_addr,
    input  logic signed [SEG_W-1:0] seg_err,
    input  logic [STAGE_BITS-1:0]   rd_addr,
    output logic signed [ERR_W-1:0] rd_data
);
    localparam int unsigned DEPTH = 1 << STAGE_BITS;

    logic signed [ERR_W-1:0] tbl [DEPTH];
    logic signed [ERR_W-1:0] seg_ext, prev_sum;

    assign seg_ext  = ERR_W'(seg_err);
    assign prev_sum = tbl[wr_addr - STAGE_BITS'(1)];
    assign rd_data  = tbl[rd_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
        end else if (wr_en && wr_addr != '0) begin
            tbl[wr_addr] <= prev_sum + seg_ext;
        end
    end

    // R6
    wr_addr_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_addr != '0));

endmodule

// File: rtl/cal_corrector.sv
module cal_corrector #(
    parameter int unsigned RAW_W     = 12,
    parameter int unsigned FRAC_BITS = 2,
    parameter int unsigned ERR_W     = 19,
    parameter int unsigned CORR_W    = 20
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     hold,
    input  logic [RAW_W-1:0]         raw_word,
    input  logic signed [ERR_W-1:0]  err,
    output logic signed [CORR_W-1:0] corr_word
);
    logic signed [CORR_W-1:0] raw_s, err_s, next_corr;

    assign raw_s     = CORR_W'($signed({1'b0, raw_word}));
    assign err_s     = CORR_W'(err);
    assign next_corr = (raw_s <<< FRAC_BITS) - err_s;

    always_ff @(posedge clk) begin
        if (rst)        corr_word <= '0;
        else if (!hold) corr_word <= next_corr;
    end

    // R8
    corr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $past(hold) |-> $stable(corr_word));

endmodule

// File: rtl/seg_cal_engine.sv
module seg_cal_engine
    import seg_cal_pkg::*;
#(
    parameter int unsigned STAGE_BITS = 3,
    parameter int unsigned RAW_W      = 12,
    parameter int unsigned BE_W       = 10,
    parameter int unsigned AVG_BITS   = 2,
    parameter int unsigned FRAC_BITS  = 2,
    parameter int unsigned IDEAL_STEP = 64,
    localparam int unsigned SEG_W     = BE_W + AVG_BITS + 2 + FRAC_BITS,
    localparam int unsigned ERR_W     = SEG_W + STAGE_BITS,
    localparam int unsigned CORR_W    = max_of(RAW_W + FRAC_BITS + 1, ERR_W) + 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cal_start,
    input  logic [STAGE_BITS-1:0]    code_in,
    input  logic [RAW_W-1:0]         raw_word,
    input  logic [BE_W-1:0]          be_result,
    output logic [STAGE_BITS-1:0]    stage_code,
    output logic                     busy,
    output logic                     done,
    output logic signed [CORR_W-1:0] corr_word
);
    cal_status_t              status;
    logic [STAGE_BITS-1:0]    cal_code, wr_addr;
    logic                     wr_en;
    logic signed [SEG_W-1:0]  seg_err;
    logic signed [ERR_W-1:0]  err_rd;

    cal_sequencer #(
        .STAGE_BITS(STAGE_BITS), .BE_W(BE_W), .AVG_BITS(AVG_BITS),
        .FRAC_BITS(FRAC_BITS), .IDEAL_STEP(IDEAL_STEP)
    ) i_seq (
        .clk(clk), .rst(rst), .start(cal_start), .be_result(be_result),
        .cal_code(cal_code), .status(status), .wr_en(wr_en),
        .wr_addr(wr_addr), .seg_err(seg_err)
    );

    cal_err_table #(
        .STAGE_BITS(STAGE_BITS), .SEG_W(SEG_W), .ERR_W(ERR_W)
    ) i_tbl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .seg_err(seg_err), .rd_addr(code_in), .rd_data(err_rd)
    );

    cal_corrector #(
        .RAW_W(RAW_W), .FRAC_BITS(FRAC_BITS), .ERR_W(ERR_W), .CORR_W(CORR_W)
    ) i_corr (
        .clk(clk), .rst(rst), .hold(status.busy), .raw_word(raw_word),
        .err(err_rd), .corr_word(corr_word)
    );

    assign busy       = status.busy;
    assign done       = status.done;
    assign stage_code = status.busy ? cal_code : code_in;

endmodule

// File: tb/test_seg_cal_engine.sv
module test_seg_cal_engine;
    localparam int NB = 3, RW = 12, BW = 10, AB = 2, FB = 2, IDEAL = 64;
    localparam int S = 1 << AB;
    localparam int NCODE = 1 << NB;
    localparam int CW = 20;

    logic clk = 0, rst = 1, cal_start = 0;
    logic [NB-1:0] code_in = '0;
    logic [RW-1:0] raw_word = '0;
    logic [BW-1:0] be_result;
    logic [NB-1:0] stage_code;
    logic busy, done;
    logic signed [CW-1:0] corr_word;

    int n_cmp = 0, n_bad = 0;
    int ncnt = 0;
    bit noise_on = 0, started = 0, finished = 0;
    int inj [NCODE] = '{0, 3, -2, 5, 1, -4, 6, 2};

    seg_cal_engine i_seg_cal_engine (
        .clk(clk), .rst(rst), .cal_start(cal_start), .code_in(code_in),
        .raw_word(raw_word), .be_result(be_result), .stage_code(stage_code),
        .busy(busy), .done(done), .corr_word(corr_word)
    );

    always #10 clk = ~clk;

    function automatic int beval(int code, int n);
        int nz;
        nz = (noise_on && (n % 3 == 0)) ? 1 : 0;
        return 200 + code * IDEAL + inj[code] + nz;
    endfunction

    assign be_result = BW'(beval(int'(stage_code), ncnt));

    // behavioural reference model
    int m_busy = 0, m_done = 0, m_corr = 0, m_code = 0, m_i = 0, sa = 0, sb = 0;
    int m_tbl [NCODE];

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_done = 0; m_corr = 0; m_i = 0; m_code = 0;
            foreach (m_tbl[k]) m_tbl[k] = 0;
        end else begin
            m_done = 0;
            if (m_busy == 0) begin
                m_corr = int'(raw_word) * 4 - m_tbl[code_in];
                if (cal_start) begin m_busy = 1; m_i = 0; m_code = 0; end
            end else begin
                int seg, r, v, d;
                seg = m_i / (2 * S);
                r = m_i % (2 * S);
                v = beval(m_code, ncnt);
                if (r < S) begin if (r == 0) sa = 0; sa += v; end
                else begin if (r == S) sb = 0; sb += v; end
                if (r == 2 * S - 1) begin
                    d = ((sb - sa - IDEAL * S) * 4) >>> AB;
                    m_tbl[seg + 1] = m_tbl[seg] + d;
                    if (seg + 1 == NCODE - 1) begin m_busy = 0; m_done = 1; end
                end
                m_i++;
                m_code = m_i / (2 * S) + (((m_i % (2 * S)) >= S) ? 1 : 0);
            end
        end
        started = 1;
    end

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        ncnt++;
        if (started && !finished) begin
            check("R2 busy", int'(busy), m_busy);
            check("R9 done", int'(done), m_done);
            check("R3/R4 stage_code", int'(stage_code), (m_busy != 0) ? m_code : int'(code_in));
            check("R1/R7/R8 corr_word", int'(corr_word), m_corr);
        end
    end

    int busy_cycles = 0;
    always @(negedge clk) if (busy) busy_cycles++;

    task automatic drive(int c, int raw, bit st);
        @(posedge clk); #2;
        code_in = NB'(c); raw_word = RW'(raw); cal_start = st;
    endtask

    task automatic run_cal;
        busy_cycles = 0;
        drive(0, 0, 1);
        drive(3, 77, 0);
        repeat (5) @(posedge clk);
        #2 cal_start = 1;               // R2: ignored while busy
        code_in = 5; raw_word = 999;    // R8: held while busy
        @(posedge clk); #2 cal_start = 0;
        while (!done) @(negedge clk);
        check("R2 busy length", busy_cycles, (NCODE - 1) * 2 * S);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 0;
        @(negedge clk);
        check("R1 reset corr", int'(corr_word), 0);
        check("R1 reset busy", int'(busy), 0);
        // R7: table is zero before any sweep
        for (int k = 0; k < 6; k++) begin
            drive(k, k * 37 + 5, 0);
            @(posedge clk); @(negedge clk);
            check("R7 pre-cal corr", int'(corr_word), (k * 37 + 5) * 4);
        end
        noise_on = 0;
        run_cal();
        // R10: linearity after a noise-free sweep
        for (int k = 0; k < NCODE; k++) begin
            for (int v = 0; v < 64; v += 21) begin
                drive(k, k * IDEAL + inj[k] + v, 0);
                @(posedge clk); @(negedge clk);
                check("R10 linear corr", int'(corr_word), 4 * (k * IDEAL + v + inj[0]));
            end
        end
        noise_on = 1;
        run_cal();
        // R5/R6: fractional table entries are seen through corr_word by the model
        for (int k = 0; k < NCODE; k++) begin
            drive(k, 300 + k, 0);
            @(posedge clk); @(negedge clk);
            check("R5/R6 table via corr", int'(corr_word), (300 + k) * 4 - m_tbl[k]);
        end
        drive(2, 10, 0);
        @(posedge clk); @(negedge clk);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule